// File: doc/BRIEF.md
# DRAM Rank Power and Refresh Sequencer

This block runs one memory rank through its low-power states and fits periodic refresh in among them. It watches how much work the controller has queued for the rank, how many commands are still in flight and how many banks are open. From that it decides when the rank may drop into active or precharge power-down, when it must wake, and how a due refresh is carried out from whichever state the rank is in. Every decision leaves the block as a one-cycle command pulse with a type code. A busy flag tells the scheduler that the rank cannot take reads or writes.

Refresh and power-down are interleaved. A rank sitting in active power-down wakes, closes its banks and refreshes. A rank sitting in precharge power-down wakes, waits the exit time and then, if it still has no work and no drain is pending, goes straight into self-refresh instead of issuing an auto-refresh. All timing values are parameters counted in clock cycles.

Top module: `rank_pwr_seq`

## Requirements
- R1: After reset, `cmd_valid`, `busy` and `err_sticky` are low and the rank is in the active state.
- R2: Each command is a one-cycle `cmd_valid` pulse whose `cmd_type` is 1 precharge-all, 2 refresh, 3 enter active power-down, 4 enter precharge power-down, 5 power-down exit, 6 self-refresh entry, 7 self-refresh exit. `busy` is high whenever the rank is not in the active state.
- R3: The queue counts as empty by `dir_wr`: when it is 0 only `rd_cnt` is tested, when it is 1 only `wr_cnt` is tested.
- R4: From the active state the rank enters low power only when the queue is empty and `outstanding` is zero. With banks open it enters active power-down (3), otherwise precharge power-down (4). Entering from a wake with no refresh takes T_XP+1 cycles after the exit command.
- R5: No power-down exit or self-refresh exit is issued earlier than T_CKE cycles after the entry command.
- R6: Work arriving in a power-down state without a due refresh causes an exit (5). `busy` falls T_XP cycles after that command.
- R7: A refresh falling due in active power-down gives an exit (5), a precharge-all T_XP+1 cycles later, and a refresh T_RP cycles after the precharge-all.
- R8: A refresh falling due in precharge power-down gives an exit (5) and, T_XP cycles later, self-refresh entry (6) if the queue is empty and `drain_hold` is low, otherwise a refresh (2).
- R9: T_RFC cycles after a refresh command the refresh completes. With the queue empty the rank enters precharge power-down (4) in that cycle, otherwise it returns to active.
- R10: The next refresh falls due T_REFI-T_RP cycles after a refresh completes. A rank kept active with its banks closed therefore issues refreshes T_RFC+T_REFI-T_RP cycles apart.
- R11: In self-refresh, queued work or `drain_hold` gives self-refresh exit (7). The next refresh falls due T_XS cycles after that exit and, with no banks open, is issued directly.
- R12: `err_sticky` rises in the cycle a refresh completes if `outstanding` is not exactly 1 at that point, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_cnt | input | QW | Read-queue entries for this rank |
| wr_cnt | input | QW | Write-queue entries for this rank |
| dir_wr | input | 1 | Next bus direction: 0 read, 1 write |
| outstanding | input | OW | Commands issued but not yet complete, refresh included |
| open_banks | input | BW | Number of banks currently open |
| drain_hold | input | 1 | Drain requested or completed; blocks the self-refresh bypass |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_type | output | 3 | Command code, valid with `cmd_valid` |
| busy | output | 1 | Rank not available for reads or writes |
| err_sticky | output | 1 | Outstanding count was wrong at a refresh completion |

## Verification
The assertions assume that the scheduler keeps `outstanding` at one while a refresh runs, that `open_banks` drops to zero once precharge-all has taken effect, and that the inputs change only between clock edges. The bench plays that scheduler. Whenever a command appears, it answers by updating banks, queue and outstanding counts. It breaks the outstanding rule only in the one refresh that tests the sticky error. The refresh-from-power-down orderings and the bypass decision are reached by parking the rank in each low-power state until the refresh interval expires.

// File: rtl/rank_pwr_pkg.sv
// Shared command codes and controller states for the rank power sequencer.
// Assumes a 3-bit command bus where 0 means no command.
package rank_pwr_pkg;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_PALL     = 3'd1,
        CMD_AREF     = 3'd2,
        CMD_PD_ACT   = 3'd3,
        CMD_PD_PRE   = 3'd4,
        CMD_PD_EXIT  = 3'd5,
        CMD_SR_ENTER = 3'd6,
        CMD_SR_EXIT  = 3'd7
    } rank_cmd_e;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_ACT_PD,
        ST_PRE_PD,
        ST_SELF_REF,
        ST_WAIT_RP,
        ST_WAIT_XP,
        ST_REFRESH
    } rank_st_e;

endpackage

// File: rtl/rank_queue_idle.sv
// Decides whether the rank has no queued work, looking only at the queue
// that matches the next bus direction. Assumes counts are already per rank.
module rank_queue_idle #(
    parameter int QW = 6
) (
    input  logic [QW-1:0] rd_cnt,
    input  logic [QW-1:0] wr_cnt,
    input  logic          dir_wr,
    output logic          q_idle
);

    // Select the queue by direction and test it for zero.
    always_comb begin
        q_idle = dir_wr ? (wr_cnt == '0) : (rd_cnt == '0);
    end

endmodule

// File: rtl/rank_cycle_timer.sv
// Loadable down-counter that stops at zero; done is high while it rests at
// zero. Loading N-1 gives the next action exactly N cycles after the load.
module rank_cycle_timer #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    // Count down towards zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= RST_VAL;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // Timer rests at zero until reloaded (timing base for R5 and R9).
    assert_timer_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

endmodule

// File: rtl/rank_pwr_seq.sv
// Per-rank power and refresh sequencer. Moves the rank between active,
// active power-down, precharge power-down and self-refresh, and runs refresh
// from any of them. Assumes the scheduler counts the refresh itself in
// `outstanding` and clears `open_banks` after a precharge-all.
module rank_pwr_seq
    import rank_pwr_pkg::*;
#(
    parameter int QW     = 6,
    parameter int OW     = 4,
    parameter int BW     = 4,
    parameter int TW     = 16,
    parameter int T_REFI = 200,
    parameter int T_RP   = 4,
    parameter int T_RFC  = 20,
    parameter int T_XP   = 3,
    parameter int T_XS   = 24,
    parameter int T_CKE  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [QW-1:0] rd_cnt,
    input  logic [QW-1:0] wr_cnt,
    input  logic          dir_wr,
    input  logic [OW-1:0] outstanding,
    input  logic [BW-1:0] open_banks,
    input  logic          drain_hold,
    output logic          cmd_valid,
    output logic [2:0]    cmd_type,
    output logic          busy,
    output logic          err_sticky
);

    localparam logic [TW-1:0] LD_RP   = TW'(T_RP - 1);
    localparam logic [TW-1:0] LD_RFC  = TW'(T_RFC - 1);
    localparam logic [TW-1:0] LD_XP   = TW'(T_XP - 1);
    localparam logic [TW-1:0] LD_XS   = TW'(T_XS - 1);
    localparam logic [TW-1:0] LD_CKE  = TW'(T_CKE - 1);
    localparam logic [TW-1:0] LD_REFI = TW'(T_REFI - 1);
    localparam logic [TW-1:0] LD_NEXT = TW'(T_REFI - T_RP - 1);
    localparam int            SMAX    = (T_CKE > T_RP) ? T_CKE : T_RP;
    localparam int            SW      = $clog2(SMAX + 2);

    rank_st_e      st, st_nxt;
    rank_cmd_e     cmd_nxt;
    logic          q_idle, wait_done, ref_due;
    logic          w_load, r_load, err_set;
    logic [TW-1:0] w_val, r_val;
    logic          xp_for_ref, xp_for_ref_nxt;

    rank_queue_idle #(.QW(QW)) u_qidle (
        .rd_cnt (rd_cnt),
        .wr_cnt (wr_cnt),
        .dir_wr (dir_wr),
        .q_idle (q_idle)
    );

    rank_cycle_timer #(.W(TW), .RST_VAL('0)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (w_load),
        .load_val (w_val),
        .done     (wait_done)
    );

    rank_cycle_timer #(.W(TW), .RST_VAL(LD_REFI)) u_refi (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (r_load),
        .load_val (r_val),
        .done     (ref_due)
    );

    // Next-state, command and timer-load decisions.
    always_comb begin
        st_nxt         = st;
        cmd_nxt        = CMD_NONE;
        w_load         = 1'b0;
        w_val          = '0;
        r_load         = 1'b0;
        r_val          = '0;
        err_set        = 1'b0;
        xp_for_ref_nxt = xp_for_ref;
        unique case (st)
            ST_ACTIVE: begin
                if (ref_due) begin
                    if (open_banks != '0) begin
                        cmd_nxt = CMD_PALL;  st_nxt = ST_WAIT_RP; w_load = 1'b1; w_val = LD_RP;
                    end else begin
                        cmd_nxt = CMD_AREF;  st_nxt = ST_REFRESH; w_load = 1'b1; w_val = LD_RFC;
                    end
                end else if (q_idle && outstanding == '0) begin
                    w_load = 1'b1; w_val = LD_CKE;
                    if (open_banks != '0) begin
                        cmd_nxt = CMD_PD_ACT; st_nxt = ST_ACT_PD;
                    end else begin
                        cmd_nxt = CMD_PD_PRE; st_nxt = ST_PRE_PD;
                    end
                end
            end
            ST_ACT_PD: begin
                if (wait_done && (ref_due || !q_idle)) begin
                    cmd_nxt = CMD_PD_EXIT; st_nxt = ST_WAIT_XP; w_load = 1'b1; w_val = LD_XP;
                    xp_for_ref_nxt = 1'b0;
                end
            end
            ST_PRE_PD: begin
                if (wait_done && (ref_due || !q_idle)) begin
                    cmd_nxt = CMD_PD_EXIT; st_nxt = ST_WAIT_XP; w_load = 1'b1; w_val = LD_XP;
                    xp_for_ref_nxt = ref_due;
                end
            end
            ST_SELF_REF: begin
                if (wait_done && (!q_idle || drain_hold)) begin
                    cmd_nxt = CMD_SR_EXIT; st_nxt = ST_ACTIVE; r_load = 1'b1; r_val = LD_XS;
                end
            end
            ST_WAIT_RP: begin
                if (wait_done) begin
                    cmd_nxt = CMD_AREF; st_nxt = ST_REFRESH; w_load = 1'b1; w_val = LD_RFC;
                end
            end
            ST_WAIT_XP: begin
                if (wait_done) begin
                    if (!xp_for_ref) begin
                        st_nxt = ST_ACTIVE;
                    end else if (q_idle && !drain_hold) begin
                        cmd_nxt = CMD_SR_ENTER; st_nxt = ST_SELF_REF; w_load = 1'b1; w_val = LD_CKE;
                    end else begin
                        cmd_nxt = CMD_AREF; st_nxt = ST_REFRESH; w_load = 1'b1; w_val = LD_RFC;
                    end
                end
            end
            ST_REFRESH: begin
                if (wait_done) begin
                    r_load  = 1'b1;
                    r_val   = LD_NEXT;
                    err_set = (outstanding != OW'(1));
                    if (q_idle) begin
                        cmd_nxt = CMD_PD_PRE; st_nxt = ST_PRE_PD; w_load = 1'b1; w_val = LD_CKE;
                    end else begin
                        st_nxt = ST_ACTIVE;
                    end
                end
            end
            default: st_nxt = ST_ACTIVE;
        endcase
    end

    // State, registered command outputs and the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_ACTIVE;
            cmd_valid  <= 1'b0;
            cmd_type   <= CMD_NONE;
            xp_for_ref <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            st         <= st_nxt;
            cmd_valid  <= (cmd_nxt != CMD_NONE);
            cmd_type   <= cmd_nxt;
            xp_for_ref <= xp_for_ref_nxt;
            err_sticky <= err_sticky | err_set;
        end
    end

    assign busy = (st != ST_ACTIVE);

    // Checker support: cycles since the last low-power entry and precharge-all.
    logic [SW-1:0] since_pd, since_pall;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pd   <= SW'(SMAX);
            since_pall <= SW'(SMAX);
        end else begin
            if (cmd_valid && (cmd_type == CMD_PD_ACT || cmd_type == CMD_PD_PRE ||
                              cmd_type == CMD_SR_ENTER))
                since_pd <= SW'(1);
            else if (int'(since_pd) < SMAX)
                since_pd <= since_pd + 1'b1;
            if (cmd_valid && cmd_type == CMD_PALL)
                since_pall <= SW'(1);
            else if (int'(since_pall) < SMAX)
                since_pall <= since_pall + 1'b1;
        end
    end

    assert_min_residency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_type == CMD_PD_EXIT || cmd_type == CMD_SR_EXIT))
        |-> int'(since_pd) >= T_CKE);

    assert_pall_to_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == CMD_AREF) |-> int'(since_pall) >= T_RP);

    assert_bypass_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == CMD_SR_ENTER) |-> ($past(q_idle) && !$past(drain_hold)));

    assert_act_pd_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == CMD_PD_ACT)
        |-> ($past(q_idle) && $past(outstanding) == '0 && $past(open_banks) != '0));

    assert_err_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    assert_busy_on_lowpower_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_type == CMD_PD_ACT || cmd_type == CMD_SR_ENTER)) |-> busy);

endmodule

// File: tb/tb_rank_pwr_seq.sv
// Scoreboard bench: the driver queues the expected command and cycle gap,
// the monitor pops and compares each command the rank sequencer emits.
module tb_rank_pwr_seq;

    localparam int QW = 6, OW = 4, BW = 4, TW = 16;
    localparam int T_REFI = 200, T_RP = 4, T_RFC = 20, T_XP = 3, T_XS = 24, T_CKE = 3;

    localparam int C_PALL = 1, C_AREF = 2, C_PDA = 3, C_PDP = 4,
                   C_PDX = 5, C_SRE = 6, C_SRX = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [QW-1:0] rd_cnt = '0;
    logic [QW-1:0] wr_cnt = '0;
    logic          dir_wr = 1'b0;
    logic [OW-1:0] outstanding = '0;
    logic [BW-1:0] open_banks = '0;
    logic          drain_hold = 1'b0;
    logic          cmd_valid, busy, err_sticky;
    logic [2:0]    cmd_type;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_cyc = 0;

    typedef struct {
        int    code;
        int    gap;
        string req;
    } exp_t;
    exp_t exp_q[$];

    rank_pwr_seq #(
        .QW(QW), .OW(OW), .BW(BW), .TW(TW), .T_REFI(T_REFI), .T_RP(T_RP),
        .T_RFC(T_RFC), .T_XP(T_XP), .T_XS(T_XS), .T_CKE(T_CKE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .dir_wr(dir_wr),
        .outstanding(outstanding), .open_banks(open_banks), .drain_hold(drain_hold),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .busy(busy), .err_sticky(err_sticky)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: pop one expectation per command strobe.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected command", int'(cmd_type), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(cmd_type) == e.code, {e.req, " type"}, int'(cmd_type), e.code);
                if (e.gap != 0)
                    check(cyc - last_cyc == e.gap, {e.req, " gap"}, cyc - last_cyc, e.gap);
            end
            last_cyc = cyc;
        end
    end

    // Driver: queue one expected command and wait until the monitor has seen it.
    task automatic expect_cmd(input int code, input int gap, input string req);
        exp_t e;
        e.code = code; e.gap = gap; e.req = req;
        exp_q.push_back(e);
        while (exp_q.size() != 0) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        rd_cnt = 1; outstanding = 2; open_banks = 2;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(cmd_valid == 1'b0, "R1 cmd_valid", int'(cmd_valid), 0);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(err_sticky == 1'b0, "R1 err_sticky", int'(err_sticky), 0);
        #1 rst_n = 1'b1;

        // R3: write direction with writes queued keeps the rank active
        rd_cnt = 0; wr_cnt = 3; dir_wr = 1; outstanding = 0;
        idle(10);
        check(busy == 1'b0, "R3 write queue busy", int'(busy), 0);
        // R4: outstanding command blocks low power
        dir_wr = 0; outstanding = 1;
        idle(10);
        check(busy == 1'b0, "R4 outstanding blocks", int'(busy), 0);
        outstanding = 0;
        expect_cmd(C_PDA, 0, "R4 active pd entry");
        check(busy == 1'b1, "R2 busy in pd", int'(busy), 1);

        // R5: work right after entry, exit waits the residency
        rd_cnt = 1;
        expect_cmd(C_PDX, T_CKE, "R5 residency exit");
        idle(T_XP - 1);
        check(busy == 1'b1, "R6 busy during exit", int'(busy), 1);
        idle(1);
        check(busy == 1'b0, "R6 busy after exit", int'(busy), 0);

        // R8: precharge pd, refresh due, bypass into self-refresh
        rd_cnt = 0; outstanding = 0; open_banks = 0;
        expect_cmd(C_PDP, 0, "R4 precharge pd entry");
        expect_cmd(C_PDX, 0, "R8 exit for refresh");
        expect_cmd(C_SRE, T_XP, "R8 self-refresh bypass");
        idle(10);
        check(busy == 1'b1, "R2 busy in self-refresh", int'(busy), 1);

        // R11: work ends self-refresh; refresh follows T_XS later
        rd_cnt = 1;
        expect_cmd(C_SRX, 0, "R11 self-refresh exit");
        outstanding = 2; open_banks = 0;
        expect_cmd(C_AREF, T_XS, "R11 refresh after exit");
        outstanding = 1;
        expect_cmd(C_AREF, T_RFC + T_REFI - T_RP, "R10 refresh interval");
        // R9: queue empty at completion forces precharge pd
        outstanding = 1; rd_cnt = 0;
        expect_cmd(C_PDP, T_RFC, "R9 forced pd after refresh");
        outstanding = 0;
        check(err_sticky == 1'b0, "R12 no error", int'(err_sticky), 0);

        // R6 and R4: wake, then fall into active pd
        rd_cnt = 1;
        expect_cmd(C_PDX, 0, "R6 wake on work");
        rd_cnt = 0; open_banks = 2; outstanding = 0;
        expect_cmd(C_PDA, T_XP + 1, "R4 entry after wake");

        // R7: refresh from active pd
        expect_cmd(C_PDX, 0, "R7 exit for refresh");
        expect_cmd(C_PALL, T_XP + 1, "R7 precharge-all");
        open_banks = 0;
        expect_cmd(C_AREF, T_RP, "R7 refresh after precharge");
        outstanding = 1;
        expect_cmd(C_PDP, T_RFC, "R9 pd after refresh");
        outstanding = 0;

        // R8 with drain pending: refresh instead of bypass; R12 error
        drain_hold = 1;
        expect_cmd(C_PDX, 0, "R8 exit with drain");
        expect_cmd(C_AREF, T_XP, "R8 drain blocks bypass");
        outstanding = 2;
        expect_cmd(C_PDP, T_RFC, "R9 pd after drained refresh");
        check(err_sticky == 1'b1, "R12 error raised", int'(err_sticky), 1);
        outstanding = 0;
        idle(5);
        check(err_sticky == 1'b1, "R12 error sticky", int'(err_sticky), 1);
        check(busy == 1'b1, "R2 busy in pd", int'(busy), 1);

        check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule